// File: doc/BRIEF.md
# Dual-Channel Serial Converter Loader

This block is the digital front end of a two-channel 12-bit converter. A host sends 16-bit frames over three wires: an active-low frame enable, a serial clock and a data line. Each frame carries a channel-select bit and a 12-bit code. The block keeps a pending code for each channel. It drives two 12-bit output latches, which an analog stage downstream turns into voltages. All serial pins are asynchronous to the fast system clock. Each pin passes through a two-flop synchronizer, and the falling edges of the frame enable, the serial clock and the load strobe are detected in the system clock domain.

The level of the active-low load strobe is taken in the cycle that the start of a frame is detected, and it sets that frame's update mode. With the strobe low, the frame is immediate: the selected output latch takes the code on the sixteenth falling serial clock edge. With the strobe high, the frame is deferred: only the pending register is written. A later falling edge of the strobe copies both pending registers into both output latches together. An active-low clear input empties the shift path and zeroes both pending registers and both output latches. Each output latch has its own one-cycle update pulse.

The frame controller has four states. `ST_IDLE` waits for a frame start. `ST_SHIFT` takes in bits, and it goes back to `ST_IDLE` when the frame enable rises early. `ST_FULL` is entered on the sixteenth bit and ignores all further serial clocks. `ST_ARMED` holds a completed deferred frame after the frame enable rises. The transitions are:
- start: `ST_IDLE` to `ST_SHIFT`, or `ST_ARMED` to `ST_SHIFT`.
- abort: `ST_SHIFT` to `ST_IDLE`.
- complete: `ST_SHIFT` to `ST_FULL`.
- release: `ST_FULL` to `ST_IDLE`, or to `ST_ARMED` while a deferred load is outstanding.
- strobe: `ST_ARMED` to `ST_IDLE`.
- clear: any state to `ST_IDLE`.

Top module: `dual_dac_loader`

## Requirements
- R1: After reset both output latches read zero and both update pulses are low.
- R2: A frame is 16 bits, first bit first. Bits 15..13 (the first three) are ignored. Bit 12 (the fourth) selects the channel. Bits 11..0 are the code, most significant bit first. Data is taken on falling serial clock edges while the frame enable is low.
- R3: A select bit of 0 targets channel A and a select bit of 1 targets channel B. The other channel's latch is unchanged.
- R4: After the sixteenth falling edge of a frame, further serial clock edges in the same frame have no effect.
- R5: If the frame enable rises before 16 bits have arrived, the partial frame is discarded and no pending register or latch changes. The next frame is decoded from its own first bit.
- R6: In deferred mode the output latches do not change at the end of the frame. The first falling edge of the load strobe after the sixteenth bit loads both latches from their pending registers.
- R7: A falling edge of the load strobe has no effect while no deferred frame is complete and unloaded.
- R8: A low clear input zeroes the shift path, both pending registers and both output latches.
- R9: Each latch load raises that channel's update pulse for exactly one system clock cycle. A clear raises no pulse, and a latch never changes without a pulse or a clear.
- R10: Serial clock edges while the frame enable is high are ignored.
- R11: The mode is fixed by the strobe level at frame start. A change of the strobe level later in the frame does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Serial frame enable, active low |
| sclk | input | 1 | Serial clock; data taken on falling edges |
| sdata | input | 1 | Serial data |
| load_n | input | 1 | Mode select at frame start; falling edge is the joint load strobe |
| clear_n | input | 1 | Clear, active low |
| chan_a | output | 12 | Channel A output latch |
| chan_b | output | 12 | Channel B output latch |
| upd_a | output | 1 | One-cycle pulse when chan_a loads |
| upd_b | output | 1 | One-cycle pulse when chan_b loads |

## Verification
The bench sends frames with extra trailing serial clocks. A loader without the sixteen-edge lock would shift those clocks in and corrupt the code. The bench sends a frame cut short and then a full one. A design that keeps the partial count would decode the second frame misaligned. It sends serial clocks with the frame enable high, which a careless design would count. It changes the strobe level in mid-frame. A design that reads the level continuously would switch modes or take the mid-frame falling edge as a load. It checks that a clear also empties the pending registers, which a design that clears only the outputs would reload after the next strobe.

// File: rtl/dac_ldr_pkg.sv
package dac_ldr_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CODE_BITS  = 12;
    localparam int NUM_CHAN   = 2;

    // pin positions inside the synchronizer vector
    localparam int PIN_FRM  = 0;
    localparam int PIN_SCK  = 1;
    localparam int PIN_SDI  = 2;
    localparam int PIN_LD   = 3;
    localparam int PIN_CLR  = 4;
    localparam int NUM_PINS = 5;

    // idle levels loaded into the synchronizers at reset
    localparam logic [NUM_PINS-1:0] PIN_RST = 5'b11011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_FULL,
        ST_ARMED
    } ldr_state_e;

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
    parameter int            WIDTH   = 5,
    parameter int            STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            logic [STAGES-1:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RST_VAL[gi]}};
                end else begin
                    chain <= {chain[STAGES-2:0], pin_i[gi]};
                end
            end

            assign lvl_o[gi] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/dac_frame_fsm.sv
module dac_frame_fsm
    import dac_ldr_pkg::*;
#(
    parameter int FRAME_W = FRAME_BITS,
    parameter int DATA_W  = CODE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_act,
    input  logic              frm_lvl,
    input  logic              sck_lvl,
    input  logic              sdi_lvl,
    input  logic              ld_lvl,
    output logic              wr_en,
    output logic              wr_ch,
    output logic [DATA_W-1:0] wr_data,
    output logic              auto_ld,
    output logic              joint_ld,
    output logic              ld_fall,
    output ldr_state_e        state_o
);

    localparam int              CNT_W = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    ldr_state_e        state;
    ldr_state_e        nxt;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] hold;
    logic              defer;
    logic              armed;
    logic              frm_q;
    logic              sck_q;
    logic              ld_q;
    logic              frm_fall;
    logic              frm_rise;
    logic              sck_fall;
    logic              start;
    logic              shift;

    assign frm_fall = frm_q & ~frm_lvl;
    assign frm_rise = ~frm_q & frm_lvl;
    assign sck_fall = sck_q & ~sck_lvl;
    assign ld_fall  = ld_q & ~ld_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and control outputs
    always_comb begin
        nxt      = state;
        start    = 1'b0;
        shift    = 1'b0;
        wr_en    = 1'b0;
        joint_ld = 1'b0;
        if (clr_act) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (frm_fall) begin
                        start = 1'b1;
                        nxt   = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (frm_rise) begin
                        nxt = ST_IDLE;
                    end else if (sck_fall) begin
                        shift = 1'b1;
                        if (cnt == LAST) begin
                            wr_en = 1'b1;
                            nxt   = ST_FULL;
                        end
                    end
                end
                ST_FULL: begin
                    if (armed && ld_fall) begin
                        joint_ld = 1'b1;
                    end
                    if (frm_rise) begin
                        nxt = (armed && !ld_fall) ? ST_ARMED : ST_IDLE;
                    end
                end
                ST_ARMED: begin
                    if (ld_fall) begin
                        joint_ld = 1'b1;
                        nxt      = ST_IDLE;
                    end else if (frm_fall) begin
                        start = 1'b1;
                        nxt   = ST_SHIFT;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    assign wr_data = {hold[DATA_W-2:0], sdi_lvl};
    assign wr_ch   = hold[DATA_W-1];
    assign auto_ld = wr_en & ~defer;
    assign state_o = state;

    // edge history, bit counter, hold register, mode flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= 1'b1;
            sck_q <= 1'b1;
            ld_q  <= 1'b1;
            cnt   <= '0;
            hold  <= '0;
            defer <= 1'b0;
            armed <= 1'b0;
        end else begin
            frm_q <= frm_lvl;
            sck_q <= sck_lvl;
            ld_q  <= ld_lvl;
            if (clr_act) begin
                cnt   <= '0;
                hold  <= '0;
                defer <= 1'b0;
                armed <= 1'b0;
            end else begin
                if (start) begin
                    cnt   <= '0;
                    defer <= ld_lvl;
                    armed <= 1'b0;
                end
                if (shift) begin
                    hold <= {hold[DATA_W-2:0], sdi_lvl};
                    cnt  <= cnt + 1'b1;
                end
                if (wr_en) begin
                    cnt   <= '0;
                    armed <= defer;
                end
                if (joint_ld) begin
                    armed <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank #(
    parameter int DATA_W = 12,
    parameter int NUM_CH = 2,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_act,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     auto_ld,
    input  logic                     joint_ld,
    output logic [NUM_CH*DATA_W-1:0] out_flat,
    output logic [NUM_CH-1:0]        upd
);

    genvar gc;
    generate
        for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
            logic [DATA_W-1:0] pend;
            logic [DATA_W-1:0] outq;
            logic              hit;

            assign hit = (wr_ch == CH_W'(gc));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend    <= '0;
                    outq    <= '0;
                    upd[gc] <= 1'b0;
                end else if (clr_act) begin
                    pend    <= '0;
                    outq    <= '0;
                    upd[gc] <= 1'b0;
                end else begin
                    upd[gc] <= 1'b0;
                    if (wr_en && hit) begin
                        pend <= wr_data;
                    end
                    if (auto_ld && hit) begin
                        outq    <= wr_data;
                        upd[gc] <= 1'b1;
                    end
                    if (joint_ld) begin
                        outq    <= pend;
                        upd[gc] <= 1'b1;
                    end
                end
            end

            assign out_flat[gc*DATA_W +: DATA_W] = outq;
        end
    endgenerate

endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
    import dac_ldr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        sclk,
    input  logic        sdata,
    input  logic        load_n,
    input  logic        clear_n,
    output logic [11:0] chan_a,
    output logic [11:0] chan_b,
    output logic        upd_a,
    output logic        upd_b
);

    logic [NUM_PINS-1:0]           pins;
    logic [NUM_PINS-1:0]           lvl;
    logic                          clr_act;
    logic                          wr_en;
    logic                          wr_ch;
    logic [CODE_BITS-1:0]          wr_data;
    logic                          auto_ld;
    logic                          joint_ld;
    logic                          ld_fall;
    ldr_state_e                    state;
    logic [NUM_CHAN*CODE_BITS-1:0] out_flat;
    logic [NUM_CHAN-1:0]           upd;

    assign pins[PIN_FRM] = frame_n;
    assign pins[PIN_SCK] = sclk;
    assign pins[PIN_SDI] = sdata;
    assign pins[PIN_LD]  = load_n;
    assign pins[PIN_CLR] = clear_n;

    dac_pin_sync #(
        .WIDTH   (NUM_PINS),
        .STAGES  (2),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pins),
        .lvl_o (lvl)
    );

    assign clr_act = ~lvl[PIN_CLR];

    dac_frame_fsm #(
        .FRAME_W (FRAME_BITS),
        .DATA_W  (CODE_BITS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_act  (clr_act),
        .frm_lvl  (lvl[PIN_FRM]),
        .sck_lvl  (lvl[PIN_SCK]),
        .sdi_lvl  (lvl[PIN_SDI]),
        .ld_lvl   (lvl[PIN_LD]),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_data  (wr_data),
        .auto_ld  (auto_ld),
        .joint_ld (joint_ld),
        .ld_fall  (ld_fall),
        .state_o  (state)
    );

    dac_latch_bank #(
        .DATA_W (CODE_BITS),
        .NUM_CH (NUM_CHAN)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_act  (clr_act),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_data  (wr_data),
        .auto_ld  (auto_ld),
        .joint_ld (joint_ld),
        .out_flat (out_flat),
        .upd      (upd)
    );

    assign chan_a = out_flat[CODE_BITS-1:0];
    assign chan_b = out_flat[2*CODE_BITS-1:CODE_BITS];
    assign upd_a  = upd[0];
    assign upd_b  = upd[1];

endmodule

// File: rtl/dac_ldr_chk.sv
module dac_ldr_chk
    import dac_ldr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [11:0] chan_a,
    input logic [11:0] chan_b,
    input logic        upd_a,
    input logic        upd_b,
    input logic        clr_act,
    input logic        ld_fall,
    input ldr_state_e  state
);

    // R9: a latch moves only with its pulse or after a clear
    p_a_change_pulsed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_a != $past(chan_a)) |-> (upd_a || $past(clr_act)));

    p_b_change_pulsed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_b != $past(chan_b)) |-> (upd_b || $past(clr_act)));

    // R9: pulses last one cycle
    p_a_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_a |=> !upd_a);

    p_b_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_b |=> !upd_b);

    // R8: clear zeroes both latches without pulses
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (chan_a == '0 && chan_b == '0 && !upd_a && !upd_b));

    // R6: a joint update follows a strobe edge
    p_joint_on_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_a && upd_b) |-> $past(ld_fall));

    // R8: clear forces the controller idle
    p_clear_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (state == ST_IDLE));

endmodule

bind dual_dac_loader dac_ldr_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .chan_a  (chan_a),
    .chan_b  (chan_b),
    .upd_a   (upd_a),
    .upd_b   (upd_b),
    .clr_act (clr_act),
    .ld_fall (ld_fall),
    .state   (state)
);

// File: tb/dual_dac_loader_bench.sv
module dual_dac_loader_bench;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic        load_n = 1'b1;
    logic        clear_n = 1'b1;
    logic [11:0] chan_a;
    logic [11:0] chan_b;
    logic        upd_a;
    logic        upd_b;

    int    tests = 0;
    int    fails = 0;
    int    na = 0;
    int    nb = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    dual_dac_loader u_dual_dac_loader (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .sclk    (sclk),
        .sdata   (sdata),
        .load_n  (load_n),
        .clear_n (clear_n),
        .chan_a  (chan_a),
        .chan_b  (chan_b),
        .upd_a   (upd_a),
        .upd_b   (upd_b)
    );

    // behavioural reference: pin samples delayed two edges, edges vs. one more
    bit f1, f2, f3, s1, s2, s3, d1, d2, l1, l2, l3, c1, c2;
    int          m_state;
    int          m_cnt;
    logic [15:0] m_sh;
    logic [11:0] m_pend [2];
    logic [11:0] m_out [2];
    bit          m_upd [2];
    bit          m_defer, m_armed;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {f1, f2, f3, s1, s2, s3, l1, l2, l3, c1, c2} = '1;
            {d1, d2} = '0;
            m_state = 0; m_cnt = 0; m_sh = '0;
            m_pend[0] = '0; m_pend[1] = '0; m_out[0] = '0; m_out[1] = '0;
            m_upd[0] = 0; m_upd[1] = 0; m_defer = 0; m_armed = 0;
        end else begin
            bit ff, fr, sf, lf;
            logic [15:0] w;
            ff = f3 & !f2; fr = !f3 & f2; sf = s3 & !s2; lf = l3 & !l2;
            m_upd[0] = 0; m_upd[1] = 0;
            if (!c2) begin
                m_state = 0; m_cnt = 0; m_sh = '0; m_defer = 0; m_armed = 0;
                m_pend[0] = '0; m_pend[1] = '0; m_out[0] = '0; m_out[1] = '0;
            end else begin
                case (m_state)
                    0: if (ff) begin m_state = 1; m_cnt = 0; m_defer = l2; m_armed = 0; end
                    1: if (fr) m_state = 0;
                       else if (sf) begin
                           w = {m_sh[14:0], d2};
                           m_sh = w;
                           if (m_cnt == 15) begin
                               m_pend[w[12]] = w[11:0];
                               if (m_defer) m_armed = 1;
                               else begin m_out[w[12]] = w[11:0]; m_upd[w[12]] = 1; end
                               m_cnt = 0; m_state = 2;
                           end else m_cnt++;
                       end
                    2: begin
                        if (m_armed && lf) begin
                            m_out[0] = m_pend[0]; m_out[1] = m_pend[1];
                            m_upd[0] = 1; m_upd[1] = 1; m_armed = 0;
                        end
                        if (fr) m_state = m_armed ? 3 : 0;
                    end
                    default: begin
                        if (lf) begin
                            m_out[0] = m_pend[0]; m_out[1] = m_pend[1];
                            m_upd[0] = 1; m_upd[1] = 1; m_armed = 0; m_state = 0;
                        end else if (ff) begin
                            m_state = 1; m_cnt = 0; m_defer = l2; m_armed = 0;
                        end
                    end
                endcase
            end
            f3 = f2; f2 = f1; f1 = frame_n;
            s3 = s2; s2 = s1; s1 = sclk;
            d2 = d1; d1 = sdata;
            l3 = l2; l2 = l1; l1 = load_n;
            c2 = c1; c1 = clear_n;
        end
    end

    // compare with the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (chan_a !== m_out[0] || chan_b !== m_out[1] ||
                upd_a !== m_upd[0] || upd_b !== m_upd[1]) begin
                fails++;
                $display("FAIL %s cycle: a=%h b=%h ua=%b ub=%b exp a=%h b=%h ua=%b ub=%b",
                         cur_req, chan_a, chan_b, upd_a, upd_b,
                         m_out[0], m_out[1], m_upd[0], m_upd[1]);
            end
            if (upd_a) na++;
            if (upd_b) nb++;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] frm(input logic [2:0] junk, input bit sel, input logic [11:0] code);
        return {junk, sel, code};
    endfunction

    task automatic send(input logic [15:0] w, input bit ld, input int nbits, input int extra, input bit flip);
        load_n = ld; wt(HALF);
        frame_n = 1'b0; wt(HALF);
        if (flip) load_n = ~load_n;
        for (int i = 0; i < nbits; i++) begin
            sdata = w[15-i]; sclk = 1'b1; wt(HALF);
            sclk = 1'b0; wt(HALF);
        end
        for (int i = 0; i < extra; i++) begin
            sdata = ~sdata; sclk = 1'b1; wt(HALF);
            sclk = 1'b0; wt(HALF);
        end
        wt(HALF); frame_n = 1'b1; wt(2*HALF);
    endtask

    task automatic strobe();
        load_n = 1'b1; wt(6); load_n = 1'b0; wt(6); load_n = 1'b1; wt(6);
    endtask

    initial begin
        int pa, pb;
        wt(5); rst_n = 1'b1; wt(3);
        cur_req = "R1";
        chk("R1", "chan_a after reset", chan_a, 0);
        chk("R1", "chan_b after reset", chan_b, 0);
        chk("R1", "pulses after reset", {upd_a, upd_b}, 0);

        cur_req = "R2";
        pa = na;
        send(frm(3'b111, 0, 12'hA5C), 0, 16, 0, 0);
        chk("R2", "chan_a immediate frame", chan_a, 12'hA5C);
        chk("R9", "single pulse on chan_a", na - pa, 1);
        cur_req = "R3";
        send(frm(3'b000, 1, 12'h3C7), 0, 16, 0, 0);
        chk("R3", "chan_b selected", chan_b, 12'h3C7);
        chk("R3", "chan_a untouched", chan_a, 12'hA5C);

        cur_req = "R4";
        send(frm(3'b010, 0, 12'h123), 0, 16, 5, 0);
        chk("R4", "extra clocks locked out", chan_a, 12'h123);

        cur_req = "R10";
        for (int i = 0; i < 10; i++) begin
            sdata = i[0]; sclk = 1'b1; wt(HALF); sclk = 1'b0; wt(HALF);
        end
        chk("R10", "idle clocks ignored", chan_a, 12'h123);
        send(frm(3'b101, 1, 12'h0F0), 0, 16, 0, 0);
        chk("R10", "next frame aligned", chan_b, 12'h0F0);

        cur_req = "R5";
        send(frm(3'b000, 0, 12'hFFF), 0, 10, 0, 0);
        chk("R5", "partial frame discarded", chan_a, 12'h123);
        send(frm(3'b110, 1, 12'h456), 0, 16, 0, 0);
        chk("R5", "frame after partial", chan_b, 12'h456);

        cur_req = "R6";
        send(frm(3'b001, 0, 12'h789), 1, 16, 0, 0);
        send(frm(3'b011, 1, 12'hABC), 1, 16, 0, 0);
        chk("R6", "no auto update a", chan_a, 12'h123);
        chk("R6", "no auto update b", chan_b, 12'h456);
        pa = na; pb = nb;
        strobe();
        chk("R6", "joint load a", chan_a, 12'h789);
        chk("R6", "joint load b", chan_b, 12'hABC);
        chk("R9", "joint pulses", (na - pa) + (nb - pb), 2);

        cur_req = "R7";
        strobe();
        chk("R7", "unarmed strobe a", chan_a, 12'h789);
        chk("R7", "unarmed strobe b", chan_b, 12'hABC);

        cur_req = "R11";
        send(frm(3'b100, 0, 12'h0AA), 0, 16, 0, 1);
        chk("R11", "mode kept immediate", chan_a, 12'h0AA);
        send(frm(3'b111, 1, 12'h555), 1, 16, 0, 1);
        chk("R11", "mode kept deferred", chan_b, 12'hABC);
        strobe();
        chk("R11", "deferred load b", chan_b, 12'h555);
        chk("R11", "deferred load a", chan_a, 12'h0AA);

        cur_req = "R8";
        pa = na; pb = nb;
        clear_n = 1'b0; wt(6); clear_n = 1'b1; wt(6);
        chk("R8", "clear a", chan_a, 0);
        chk("R8", "clear b", chan_b, 0);
        chk("R9", "no pulse on clear", (na - pa) + (nb - pb), 0);
        send(frm(3'b000, 0, 12'h321), 1, 16, 0, 0);
        strobe();
        chk("R8", "pending b cleared", chan_b, 0);
        chk("R8", "pending a reloaded", chan_a, 12'h321);

        wt(10);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule